// File: doc/BRIEF.md
# Dual-Channel Interrupt Mirror Aggregator

This block is a small slice of configuration space for a two-channel disk controller. Each channel has an interrupt-pending flag. The flag is visible in two register locations: a per-channel status byte and a shared mode byte. Both copies always hold the same value, whichever one software clears. The block combines the two pending flags with two per-channel blocking masks into one level-sensitive interrupt line.

Each channel's request level is tracked by edge. A rising request sets the channel's pending flag and a falling request clears it. While the request stays high, software may clear the flag with a write-one-to-clear. The flag then stays clear until the next rising edge. The blocking masks cannot be written through the configuration port. They are loaded through a separate 2-bit side port from the bus-master register logic.

Top module: `irqm_aggregator`

## Requirements
- R1: After reset every pending and block bit is 0, `irq_o` is low, and reads of offsets 0x50, 0x57 and 0x71 return 0x00.
- R2: A rising `req_i[c]` sets channel c pending at the clock edge where the high level is first sampled. Channel 0 reads back at 0x50 bit 2 and 0x71 bit 2. Channel 1 reads back at 0x57 bit 4 and 0x71 bit 3.
- R3: A falling `req_i[c]` clears channel c pending in both locations at the edge where the low level is first sampled.
- R4: A configuration write with a 1 at a channel's status location (0x50 bit 2, 0x57 bit 4) clears that channel's pending bit in both locations. Writing 0 there changes nothing.
- R5: A configuration write to 0x71 with a 1 at bit 2 or bit 3 clears channel 0 or channel 1 pending in both locations.
- R6: Through the configuration port, no bit other than the pending bits can be changed. Block bits 0x71[5:4] and all other bits of 0x50, 0x57 and 0x71 are unaffected by any write value.
- R7: When `blk_we_i` is high, `blk_wdata_i[c]` is loaded as channel c block. Channel 0 block reads back at 0x71 bit 4 and channel 1 block at 0x71 bit 5.
- R8: `irq_o` is high exactly when (ch0 pending and not ch0 block) or (ch1 pending and not ch1 block), updating in the same edge as the state.
- R9: If a request rises in the same cycle as a write-one-to-clear of that channel's pending bit, the bit ends up set.
- R10: Writes to any offset other than 0x50, 0x57 and 0x71 have no effect, and reads of such offsets return 0x00.
- R11: After a write-one-to-clear while the request stays high, the pending bit stays clear until the request falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 2 | Per-channel interrupt request levels |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_rdata_o | output | 8 | Configuration read data for `cfg_addr_i` (combinational) |
| blk_we_i | input | 1 | Block mask write enable from the side port |
| blk_wdata_i | input | 2 | Block mask values, bit c for channel c |
| irq_o | output | 1 | Shared level-sensitive interrupt |

## Verification
The hardest case to reach is a request edge that lands in the same clock as a clear through either copy. Close behind it is a clear issued while the request is still held high, with the mask changing around it. Random stimulus toggles the request lines often and aims most writes at the three mapped offsets with random data. Directed sequences line up a rising edge with a clear in one cycle, and a clear with a request held high followed by idle cycles. The expected results come from a cycle model of the edge, clear and mask rules.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_CH   = 2;

  localparam logic [ADDR_W-1:0] OFS_STAT0 = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_STAT1 = 8'h57;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h71;

  localparam int unsigned STAT0_BIT     = 2;
  localparam int unsigned STAT1_BIT     = 4;
  localparam int unsigned MODE_PEND_LSB = 2;
  localparam int unsigned MODE_BLK_LSB  = 4;

  function automatic logic [ADDR_W-1:0] stat_addr(input int unsigned ch);
    return (ch == 0) ? OFS_STAT0 : OFS_STAT1;
  endfunction

  function automatic int unsigned stat_bit(input int unsigned ch);
    return (ch == 0) ? STAT0_BIT : STAT1_BIT;
  endfunction
endpackage

// File: rtl/irqm_cfg_decode.sv
module irqm_cfg_decode
  import irqm_pkg::*;
(
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              cfg_we_i,
  output logic [NUM_CH-1:0] w1c_stat_o,
  output logic [NUM_CH-1:0] w1c_mode_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    always_comb begin
      w1c_stat_o[c] = cfg_we_i && (cfg_addr_i == stat_addr(c)) && cfg_wdata_i[stat_bit(c)];
      w1c_mode_o[c] = cfg_we_i && (cfg_addr_i == OFS_MODE) && cfg_wdata_i[MODE_PEND_LSB + c];
    end
  end
endmodule

// File: rtl/irqm_chan.sv
module irqm_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic w1c_stat_i,
  input  logic w1c_mode_i,
  output logic pend_stat_o,
  output logic pend_mode_o,
  output logic pend_nxt_o
);
  logic req_q;
  logic stat_q, stat_d;
  logic mode_q, mode_d;
  logic rise, fall, clr;

  always_comb begin
    rise = req_i & ~req_q;
    fall = ~req_i & req_q;
    clr  = w1c_stat_i | w1c_mode_i;
    // Set has priority over any clear; a fall or a software clear drops both copies.
    if (rise) begin
      stat_d = 1'b1;
      mode_d = 1'b1;
    end else if (fall || clr) begin
      stat_d = 1'b0;
      mode_d = 1'b0;
    end else begin
      stat_d = stat_q;
      mode_d = mode_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      stat_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      req_q  <= req_i;
      stat_q <= stat_d;
      mode_q <= mode_d;
    end
  end

  assign pend_stat_o = stat_q;
  assign pend_mode_o = mode_q;
  assign pend_nxt_o  = mode_d;
endmodule

// File: rtl/irqm_mask_gate.sv
module irqm_mask_gate
  import irqm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_we_i,
  input  logic [NUM_CH-1:0] blk_wdata_i,
  input  logic [NUM_CH-1:0] pend_nxt_i,
  output logic [NUM_CH-1:0] blk_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] blk_q, blk_d;
  logic              irq_q, irq_d;

  always_comb begin
    blk_d = blk_we_i ? blk_wdata_i : blk_q;
    irq_d = |(pend_nxt_i & ~blk_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      blk_q <= blk_d;
      irq_q <= irq_d;
    end
  end

  assign blk_o = blk_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/irqm_readback.sv
module irqm_readback
  import irqm_pkg::*;
(
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [NUM_CH-1:0] pend_stat_i,
  input  logic [NUM_CH-1:0] pend_mode_i,
  input  logic [NUM_CH-1:0] blk_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] stat_byte [NUM_CH];
  logic [DATA_W-1:0] mode_byte;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_stat
    always_comb begin
      stat_byte[c] = '0;
      stat_byte[c][stat_bit(c)] = pend_stat_i[c];
    end
  end

  always_comb begin
    mode_byte = '0;
    mode_byte[MODE_PEND_LSB +: NUM_CH] = pend_mode_i;
    mode_byte[MODE_BLK_LSB  +: NUM_CH] = blk_i;
  end

  always_comb begin
    unique case (cfg_addr_i)
      OFS_STAT0: rdata_o = stat_byte[0];
      OFS_STAT1: rdata_o = stat_byte[1];
      OFS_MODE:  rdata_o = mode_byte;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irqm_aggregator.sv
module irqm_aggregator
  import irqm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              cfg_we_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              blk_we_i,
  input  logic [1:0]        blk_wdata_i,
  output logic              irq_o
);
  logic [NUM_CH-1:0] w1c_stat, w1c_mode;
  logic [NUM_CH-1:0] pend_stat, pend_mode, pend_nxt;
  logic [NUM_CH-1:0] blk_q;

  irqm_cfg_decode u_dec (
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_we_i    (cfg_we_i),
    .w1c_stat_o  (w1c_stat),
    .w1c_mode_o  (w1c_mode)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irqm_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i[c]),
      .w1c_stat_i  (w1c_stat[c]),
      .w1c_mode_i  (w1c_mode[c]),
      .pend_stat_o (pend_stat[c]),
      .pend_mode_o (pend_mode[c]),
      .pend_nxt_o  (pend_nxt[c])
    );
  end

  irqm_mask_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_we_i    (blk_we_i),
    .blk_wdata_i (blk_wdata_i),
    .pend_nxt_i  (pend_nxt),
    .blk_o       (blk_q),
    .irq_o       (irq_o)
  );

  irqm_readback u_rb (
    .cfg_addr_i  (cfg_addr_i),
    .pend_stat_i (pend_stat),
    .pend_mode_i (pend_mode),
    .blk_i       (blk_q),
    .rdata_o     (cfg_rdata_o)
  );
endmodule

// File: rtl/irqm_aggregator_chk.sv
module irqm_aggregator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req,
  input logic       cfg_we,
  input logic       blk_we,
  input logic [1:0] blk_wdata,
  input logic [1:0] pend_stat,
  input logic [1:0] pend_mode,
  input logic [1:0] blk,
  input logic       irq
);
  a_r2_rise_sets0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req[0]) |=> pend_mode[0]);
  a_r2_rise_sets1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req[1]) |=> pend_mode[1]);
  a_r3_fall_clears0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req[0]) |=> !pend_mode[0]);
  a_r3_fall_clears1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req[1]) |=> !pend_mode[1]);
  a_r4_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
    pend_stat == pend_mode);
  a_r6_blk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_we |=> $stable(blk));
  a_r7_blk_load: assert property (@(posedge clk) disable iff (!rst_n)
    blk_we |=> blk == $past(blk_wdata));
  a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(pend_stat & ~blk));
  a_r11_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (req[0] && $past(req[0]) && !pend_mode[0]) |=> !pend_mode[0] || !$past(req[0]) || $rose(req[0]) || 1'b1 ? (!pend_mode[0] || !req[0] || !$past(req[0])) : 1'b1);
endmodule

bind irqm_aggregator irqm_aggregator_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req_i),
  .cfg_we    (cfg_we_i),
  .blk_we    (blk_we_i),
  .blk_wdata (blk_wdata_i),
  .pend_stat (pend_stat),
  .pend_mode (pend_mode),
  .blk       (blk_q),
  .irq       (irq_o)
);

// File: tb/tb_irqm_aggregator.sv
module tb_irqm_aggregator;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] req_i;
  logic [7:0] cfg_addr_i, cfg_wdata_i, cfg_rdata_o;
  logic       cfg_we_i, blk_we_i, irq_o;
  logic [1:0] blk_wdata_i;

  int nchk = 0;
  int nerr = 0;
  logic [1:0] m_p, m_b, m_prev;

  always #4 clk = ~clk;

  irqm_aggregator dut (.*);

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h50:   return {5'b0, m_p[0], 2'b0};
      8'h57:   return {3'b0, m_p[1], 4'b0};
      8'h71:   return {2'b0, m_b, m_p, 2'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(m_p & ~m_b);
  endfunction

  task automatic model_step();
    for (int c = 0; c < 2; c++) begin
      logic rise, fall, clr;
      rise = req_i[c] & ~m_prev[c];
      fall = ~req_i[c] & m_prev[c];
      clr  = cfg_we_i && ((cfg_addr_i == ((c == 0) ? 8'h50 : 8'h57) &&
                           cfg_wdata_i[(c == 0) ? 2 : 4]) ||
                          (cfg_addr_i == 8'h71 && cfg_wdata_i[2 + c]));
      if (rise) m_p[c] = 1'b1;
      else if (fall || clr) m_p[c] = 1'b0;
    end
    m_prev = req_i;
    if (blk_we_i) m_b = blk_wdata_i;
  endtask

  task automatic chk_rd(input logic [7:0] a, input string tag);
    cfg_addr_i = a;
    #1;
    nchk++;
    if (cfg_rdata_o !== exp_rd(a)) begin
      nerr++;
      $display("FAIL %s: read 0x%02h got 0x%02h expected 0x%02h", tag, a, cfg_rdata_o, exp_rd(a));
    end
  endtask

  task automatic check_all(input string tag);
    cfg_we_i = 1'b0;
    blk_we_i = 1'b0;
    nchk++;
    if (irq_o !== exp_irq()) begin
      nerr++;
      $display("FAIL %s: irq got %b expected %b", tag, irq_o, exp_irq());
    end
    chk_rd(8'h50, tag);
    chk_rd(8'h57, tag);
    chk_rd(8'h71, tag);
    chk_rd(8'h52, tag);
  endtask

  task automatic cyc(input logic [1:0] rq, input logic we, input logic [7:0] a,
                     input logic [7:0] wd, input logic bwe, input logic [1:0] bd,
                     input string tag);
    req_i = rq; cfg_we_i = we; cfg_addr_i = a; cfg_wdata_i = wd;
    blk_we_i = bwe; blk_wdata_i = bd;
    @(posedge clk);
    model_step();
    #1;
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] addrs [4];
    void'($urandom(32'h1bad5eed));
    addrs[0] = 8'h50; addrs[1] = 8'h57; addrs[2] = 8'h71; addrs[3] = 8'h3c;
    m_p = '0; m_b = '0; m_prev = '0;
    rst_n = 1'b0; req_i = '0; cfg_addr_i = '0; cfg_wdata_i = '0;
    cfg_we_i = 1'b0; blk_we_i = 1'b0; blk_wdata_i = '0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    rst_n = 1'b1;
    cyc(2'b00, 0, 8'h00, 8'h00, 0, 2'b00, "R1 idle");
    // R2: rise on channel 0 then channel 1
    cyc(2'b01, 0, 8'h00, 8'h00, 0, 2'b00, "R2 rise ch0");
    cyc(2'b11, 0, 8'h00, 8'h00, 0, 2'b00, "R2 rise ch1");
    // R4: writing zero does nothing, writing one clears both copies
    cyc(2'b11, 1, 8'h50, 8'hFB, 0, 2'b00, "R4 zero write");
    cyc(2'b11, 1, 8'h50, 8'h04, 0, 2'b00, "R4 clear ch0");
    cyc(2'b11, 0, 8'h00, 8'h00, 0, 2'b00, "R11 held high stays clear");
    cyc(2'b11, 0, 8'h00, 8'h00, 0, 2'b00, "R11 held high stays clear");
    cyc(2'b11, 1, 8'h57, 8'h10, 0, 2'b00, "R4 clear ch1");
    // R3: fall clears
    cyc(2'b10, 0, 8'h00, 8'h00, 0, 2'b00, "R3 ch0 low");
    cyc(2'b01, 0, 8'h00, 8'h00, 0, 2'b00, "R2 ch0 again");
    cyc(2'b00, 0, 8'h00, 8'h00, 0, 2'b00, "R3 fall ch0");
    // R5: clear through the mode byte
    cyc(2'b11, 0, 8'h00, 8'h00, 0, 2'b00, "R2 both rise");
    cyc(2'b11, 1, 8'h71, 8'h08, 0, 2'b00, "R5 clear ch1 via mode");
    cyc(2'b11, 1, 8'h71, 8'h04, 0, 2'b00, "R5 clear ch0 via mode");
    // R7/R8: mask gating
    cyc(2'b00, 0, 8'h00, 8'h00, 1, 2'b01, "R7 block ch0");
    cyc(2'b01, 0, 8'h00, 8'h00, 0, 2'b00, "R8 masked ch0");
    cyc(2'b01, 0, 8'h00, 8'h00, 1, 2'b10, "R8 unmask ch0");
    // R6: config writes cannot touch block or other bits
    cyc(2'b01, 1, 8'h71, 8'hF3, 0, 2'b00, "R6 mode write");
    cyc(2'b01, 1, 8'h50, 8'hFB, 0, 2'b00, "R6 stat write");
    cyc(2'b01, 1, 8'h57, 8'hEF, 0, 2'b00, "R6 stat1 write");
    // R10: unmapped offset
    cyc(2'b01, 1, 8'h52, 8'hFF, 0, 2'b00, "R10 unmapped write");
    // R9: rise together with clear
    cyc(2'b00, 0, 8'h00, 8'h00, 1, 2'b00, "R3 setup");
    cyc(2'b01, 1, 8'h50, 8'h04, 0, 2'b00, "R9 rise beats clear");
    cyc(2'b11, 1, 8'h71, 8'h08, 0, 2'b00, "R9 rise beats mode clear");
    // Random phase
    for (int i = 0; i < 400; i++) begin
      logic [1:0] rq;
      rq = req_i;
      if ($urandom_range(0, 2) == 0) rq[0] = ~rq[0];
      if ($urandom_range(0, 2) == 0) rq[1] = ~rq[1];
      cyc(rq, ($urandom_range(0, 1) == 1), addrs[$urandom_range(0, 3)],
          8'($urandom), ($urandom_range(0, 4) == 0), 2'($urandom), "R8 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule